// File: doc/BRIEF.md
# Reloadable Modulus Down-Counter

This block is a 16-bit down-counter paired with a 16-bit reload register and a small clock prescaler. All accesses go through one data port. A write lands in the reload register and may also land in the live count, depending on the mode. A read returns either the live count or the reload register, chosen by a select input. The counter steps down by one only when the prescaler emits a step. The prescaler counts input enable ticks and divides them by 1, 4, 8 or 16.

The `modulus_mode` input picks one of two modes. With it high, the counter refills itself from the reload register each time it has run down to zero, so it produces a periodic zero event. A new write only changes the next period, unless a force-load strobe copies the reload value into the count at once. With it low, the counter runs once: a write clears the prescaler, loads the count directly, and the count runs down to zero and parks there.

Reaching zero sets a sticky flag, which is cleared by a strobe. Writing the value zero is a special command. It parks the counter at zero without raising the flag. When both latch enables are high, it also emits a one-cycle pulse that tells external capture holding registers to take their snapshot. The mode is an input, so one-shot operation after reset follows from `modulus_mode` being driven low.

Top module: `mod_downcounter`

## Requirements
- R1: After reset the live count, the reload register and the prescaler are zero, `zero_flag` is 0 and `latch_pulse` is 0, so `rd_data` reads 0 for either value of `read_load`.
- R2: `rd_data` shows the live count while `read_load` is 0, and the reload register while `read_load` is 1.
- R3: With `modulus_mode`=1, a nonzero write updates only the reload register. The live count keeps counting and takes the reload value on the first step after it has reached zero.
- R4: A cycle with `force_load`=1 (and no write) makes the live count equal the reload register after that edge, without waiting for zero.
- R5: With `modulus_mode`=0, a nonzero write loads both the count and the reload register at the next edge and clears the prescaler. The count then steps down to zero and stays at zero on further steps.
- R6: The count changes on steps only. A step is issued on every Nth cycle that has `tick_en`=1, counted from a cleared prescaler, with N=1, 4, 8, 16 for `ps_sel`=0, 1, 2, 3.
- R7: A step that moves the count from 1 to 0 sets `zero_flag`. A step taken at count 0 in modulus mode reloads the count and does not set the flag.
- R8: A write of 0x0000 sets both the count and the reload register to zero in either mode. It does not set `zero_flag`, even when a step would have taken the count from 1 to 0 in the same cycle. The count then remains zero.
- R9: `latch_pulse` is 1 for exactly the one cycle after a cycle with a 0x0000 write while `latch_en`=1 and `buf_en`=1. It is 0 at all other times.
- R10: `zero_flag` stays set until a cycle with `zero_clr`=1. If a set condition arrives in the same cycle as `zero_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler input tick |
| ps_sel | input | 2 | Prescale select: 0→1, 1→4, 2→8, 3→16 |
| modulus_mode | input | 1 | 1 = auto-reload, 0 = one-shot |
| read_load | input | 1 | Read select: 0 = live count, 1 = reload register |
| force_load | input | 1 | Copy the reload register into the count now |
| latch_en | input | 1 | Latch request enable |
| buf_en | input | 1 | Holding buffer enable |
| wr_en | input | 1 | Write strobe for the counter port |
| wr_data | input | 16 | Write data |
| zero_clr | input | 1 | Clear strobe for the zero flag |
| rd_data | output | 16 | Read data |
| zero_flag | output | 1 | Sticky zero/underflow flag |
| latch_pulse | output | 1 | One-cycle capture latch pulse |

## Verification
The bench builds the block with its default 16-bit count width and 4-bit prescaler counter. This lets all four divide ratios, including the divide-by-16 wrap, be reached within a few dozen cycles. Random write data is biased toward small values and toward zero. Because of that, one-shot runs to zero, modulus reloads, zero-write parking and latch pulses all occur many times within a few thousand cycles, while full-width values still exercise the upper bits of the read mux.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
    localparam int PS_SEL_W = 2;
    localparam int PS_CNT_W = 4;

    // last prescaler count before a step is issued, per select code
    function automatic logic [PS_CNT_W-1:0] ps_last(input logic [PS_SEL_W-1:0] sel);
        logic [PS_CNT_W-1:0] r;
        case (sel)
            2'd0:    r = PS_CNT_W'(0);
            2'd1:    r = PS_CNT_W'(3);
            2'd2:    r = PS_CNT_W'(7);
            default: r = PS_CNT_W'(15);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mdc_prescaler.sv
module mdc_prescaler
    import mdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [PS_SEL_W-1:0] ps_sel,
    input  logic                clr,
    output logic                step
);
    typedef struct packed {
        logic [PS_CNT_W-1:0] ps;
    } ps_state_t;

    ps_state_t cur_q, nxt_d;
    logic      wrap;

    always_comb begin
        nxt_d = cur_q;
        wrap  = (cur_q.ps >= ps_last(ps_sel));
        step  = tick_en && wrap;
        if (clr) begin
            nxt_d.ps = '0;
        end else if (tick_en) begin
            nxt_d.ps = wrap ? '0 : cur_q.ps + PS_CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/mdc_count_core.sv
module mdc_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         mod_mode,
    input  logic         force_load,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] load_q,
    output logic         hit_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] load;
    } core_t;

    core_t cur_q, nxt_d;
    logic  zero_wr;

    always_comb begin
        nxt_d    = cur_q;
        hit_zero = 1'b0;
        zero_wr  = wr_en && (wr_data == '0);
        if (wr_en) nxt_d.load = wr_data;
        if (zero_wr) begin
            nxt_d.cnt = '0;
        end else if (wr_en && !mod_mode) begin
            nxt_d.cnt = wr_data;
        end else if (force_load) begin
            nxt_d.cnt = nxt_d.load;
        end else if (step) begin
            if (cur_q.cnt == '0) begin
                if (mod_mode) nxt_d.cnt = nxt_d.load;
            end else begin
                nxt_d.cnt = cur_q.cnt - ONE;
                hit_zero  = (cur_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_q  = cur_q.cnt;
    assign load_q = cur_q.load;
endmodule

// File: rtl/mdc_flag.sv
module mdc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic latch_req,
    output logic zero_flag,
    output logic latch_pulse
);
    typedef struct packed {
        logic flag;
        logic latch;
    } flag_t;

    flag_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.latch = latch_req;
        if (set)      nxt_d.flag = 1'b1;
        else if (clr) nxt_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign zero_flag   = cur_q.flag;
    assign latch_pulse = cur_q.latch;
endmodule

// File: rtl/mod_downcounter.sv
module mod_downcounter
    import mdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [PS_SEL_W-1:0] ps_sel,
    input  logic                modulus_mode,
    input  logic                read_load,
    input  logic                force_load,
    input  logic                latch_en,
    input  logic                buf_en,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic                zero_clr,
    output logic [CNT_W-1:0]    rd_data,
    output logic                zero_flag,
    output logic                latch_pulse
);
    logic             step_w;
    logic             ps_clr_w;
    logic             hit_w;
    logic             latch_req_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] load_w;

    assign ps_clr_w    = wr_en && !modulus_mode;
    assign latch_req_w = wr_en && (wr_data == '0) && latch_en && buf_en;

    mdc_prescaler u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .ps_sel  (ps_sel),
        .clr     (ps_clr_w),
        .step    (step_w)
    );

    mdc_count_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step_w),
        .mod_mode   (modulus_mode),
        .force_load (force_load),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cnt_q      (cnt_w),
        .load_q     (load_w),
        .hit_zero   (hit_w)
    );

    mdc_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (hit_w),
        .clr         (zero_clr),
        .latch_req   (latch_req_w),
        .zero_flag   (zero_flag),
        .latch_pulse (latch_pulse)
    );

    assign rd_data = read_load ? load_w : cnt_w;
endmodule

// File: rtl/mdc_checker.sv
module mdc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         latch_en,
    input logic         buf_en,
    input logic         modulus_mode,
    input logic         force_load,
    input logic         zero_clr,
    input logic         zero_flag,
    input logic         latch_pulse,
    input logic [W-1:0] cnt_q
);
    AST_ZERO_WR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && !zero_flag) |=> !zero_flag); // R8
    AST_ZERO_WR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0) |=> (cnt_q == '0)); // R8
    AST_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |-> $past(wr_en && wr_data == '0 && latch_en && buf_en)); // R9
    AST_FLAG_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> ($past(cnt_q) == W'(1))); // R7
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!modulus_mode && cnt_q == '0 && !wr_en && !force_load) |=> (cnt_q == '0)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && !zero_clr) |=> zero_flag); // R10
endmodule

bind mod_downcounter mdc_checker #(.W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .latch_en     (latch_en),
    .buf_en       (buf_en),
    .modulus_mode (modulus_mode),
    .force_load   (force_load),
    .zero_clr     (zero_clr),
    .zero_flag    (zero_flag),
    .latch_pulse  (latch_pulse),
    .cnt_q        (cnt_w)
);

// File: tb/mod_downcounter_bench.sv
`timescale 1ns/1ps
module mod_downcounter_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 0, modulus_mode = 0, read_load = 0, force_load = 0;
    logic         latch_en = 0, buf_en = 0, wr_en = 0, zero_clr = 0;
    logic [1:0]   ps_sel = 0;
    logic [W-1:0] wr_data = 0;
    logic [W-1:0] rd_data;
    logic         zero_flag, latch_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mod_downcounter #(.CNT_W(W)) u_mod_downcounter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ps_sel(ps_sel),
        .modulus_mode(modulus_mode), .read_load(read_load), .force_load(force_load),
        .latch_en(latch_en), .buf_en(buf_en), .wr_en(wr_en), .wr_data(wr_data),
        .zero_clr(zero_clr), .rd_data(rd_data), .zero_flag(zero_flag),
        .latch_pulse(latch_pulse)
    );

    // reference state built from the requirements
    logic [W-1:0] m_cnt = 0, m_load = 0;
    int           m_ps = 0;
    logic         m_flag = 0, m_latch = 0;

    function automatic int divisor(input logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_ps = 0; m_flag = 0; m_latch = 0;
        end else begin
            logic step, hit;
            step = 0; hit = 0;
            if (tick_en) begin
                if (m_ps >= divisor(ps_sel) - 1) begin step = 1; m_ps = 0; end
                else m_ps = m_ps + 1;
            end
            if (wr_en && !modulus_mode) m_ps = 0;
            m_latch = wr_en && wr_data == 0 && latch_en && buf_en;
            if (wr_en) m_load = wr_data;
            if (wr_en && wr_data == 0) m_cnt = 0;
            else if (wr_en && !modulus_mode) m_cnt = wr_data;
            else if (force_load) m_cnt = m_load;
            else if (step) begin
                if (m_cnt == 0) begin if (modulus_mode) m_cnt = m_load; end
                else begin hit = (m_cnt == 1); m_cnt = m_cnt - 1; end
            end
            if (hit) m_flag = 1;
            else if (zero_clr) m_flag = 0;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        tick_en = 0; force_load = 0; wr_en = 0; zero_clr = 0; wr_data = 0;
    endtask

    // one clock: inputs already set, land at the following negedge
    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [W-1:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick_en = 1; cyc(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        read_load = 0; #0 chk("R1 count", rd_data, 0);
        read_load = 1; #1 chk("R1 load", rd_data, 0);
        chk("R1 flag", zero_flag, 0);
        chk("R1 latch", latch_pulse, 0);
        read_load = 0;

        // R5/R6 one-shot load, divide by 4
        modulus_mode = 0; ps_sel = 2'd1;
        wr(16'd5);
        chk("R5 load now", rd_data, 5);
        ticks(3);
        chk("R6 no step before 4th tick", rd_data, 5);
        ticks(1);
        chk("R6 step on 4th tick", rd_data, 4);
        ps_sel = 2'd0;
        ticks(4);
        chk("R5 reach zero", rd_data, 0);
        chk("R7 flag on 1 to 0", zero_flag, 1);
        ticks(3);
        chk("R5 hold at zero", rd_data, 0);

        // R10 clear and set-wins
        zero_clr = 1; cyc();
        chk("R10 cleared", zero_flag, 0);
        wr(16'd1);
        tick_en = 1; zero_clr = 1; cyc();
        chk("R10 set wins over clear", zero_flag, 1);
        zero_clr = 1; cyc();

        // R2/R3/R7 modulus reload
        wr(16'd2);
        modulus_mode = 1;
        wr(16'd7);
        chk("R2 live count", rd_data, 2);
        read_load = 1; #1 chk("R2 reload reg", rd_data, 7);
        read_load = 0;
        ticks(2);
        chk("R3 count ran down", rd_data, 0);
        chk("R7 flag in modulus", zero_flag, 1);
        zero_clr = 1; cyc();
        ticks(1);
        chk("R3 reload at zero step", rd_data, 7);
        chk("R7 no flag on reload", zero_flag, 0);

        // R4 force load
        wr(16'd9);
        chk("R3 write keeps count", rd_data, 7);
        force_load = 1; cyc();
        chk("R4 force load", rd_data, 9);

        // R8/R9 zero writes
        latch_en = 1; buf_en = 1;
        wr(16'd0);
        chk("R9 latch pulse", latch_pulse, 1);
        chk("R8 parked", rd_data, 0);
        read_load = 1; #1 chk("R8 reload zero", rd_data, 0);
        read_load = 0;
        chk("R8 no flag", zero_flag, 0);
        cyc();
        chk("R9 pulse one cycle", latch_pulse, 0);
        buf_en = 0;
        wr(16'd0);
        chk("R9 no pulse without buf_en", latch_pulse, 0);
        ticks(5);
        chk("R8 stays zero", rd_data, 0);
        modulus_mode = 0; wr(16'd1);
        tick_en = 1; wr_en = 1; wr_data = 0; cyc();
        chk("R8 zero write beats 1 to 0 step", zero_flag, 0);

        // random phase against the reference state
        for (int i = 0; i < 4000; i++) begin
            tick_en      = ($urandom_range(0, 3) != 0);
            ps_sel       = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 40) == 0) modulus_mode = ~modulus_mode;
            force_load   = ($urandom_range(0, 30) == 0);
            latch_en     = ($urandom_range(0, 1) == 1);
            buf_en       = ($urandom_range(0, 1) == 1);
            zero_clr     = ($urandom_range(0, 10) == 0);
            wr_en        = ($urandom_range(0, 15) == 0);
            case ($urandom_range(0, 3))
                0:       wr_data = 0;
                3:       wr_data = 16'($urandom);
                default: wr_data = 16'($urandom_range(1, 20));
            endcase
            @(negedge clk);
            idle();
            read_load = ($urandom_range(0, 1) == 1);
            #1;
            chk("R2 R3 R5 rd_data", rd_data, read_load ? m_load : m_cnt);
            chk("R7 R10 zero_flag", zero_flag, m_flag);
            chk("R9 latch_pulse", latch_pulse, m_latch);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end
endmodule